// File: doc/BRIEF.md
# Stoppable Channel Clock Stepper

This block sequences the internal clock steps of an I/O channel. While idle it asserts no step. A start request begins one pass through eight named steps, A0 to A7. A start request is either a data-transfer-control strobe (`dtc`) or a maintenance step pulse (`maint_pulse`). At the end of the pass the block returns to idle and waits for the next request. The upstream routine therefore sets how many passes the channel makes, one for each accepted strobe.

For diagnosis, a loadable stop register can name one step. When the pass enters that step, the block freezes there and raises `stopped`. It stays frozen until `release_stop` lets the pass go on to its end. With `free_run` high the block moves one step per clock. With `free_run` low it holds each step at a static level and moves one step per maintenance pulse.

A strobe is only accepted after `dtc` has been seen low at a clock edge. This prevents a strobe that is held high from starting a second pass. `clock_step_ctrl` signals that the block is idle and ready for a strobe.

Top module: `chan_clk_stepper`

States and transitions, named:
- IDLE: no step is asserted.
  - IDLE→RUN on a start request.
  - IDLE→HALT if step A0 is the stop step.
- RUN: a step is active.
  - RUN→RUN on an advance to a step that does not match the stop step.
  - RUN→HALT on an advance into the stop step.
  - RUN→IDLE on an advance from A7.
- HALT: the stop step is held.
  - HALT→RUN or HALT→IDLE on `release_stop`, using the same rule as an advance.

## Requirements
- R1: An asynchronous active-low reset gives idle state with `step_onehot`=0, `busy`=0, `stopped`=0 and `clock_step_ctrl`=0. It also clears the stop register, so a step loaded before the reset no longer halts a pass.
- R2: A start request is accepted only in idle. It is `maint_pulse`=1, or `dtc`=1 while armed. Step A0 appears on the clock after the accepting edge. A strobe and a pulse that arrive on the same edge start only one pass.
- R3: With `free_run`=1 the pass moves one step per clock from A0 to A7. Step Ak is shown as `step_onehot` bit k. After A7 the block returns to idle.
- R4: The block becomes armed at any edge where `dtc`=0. Arming is lost when a strobe is accepted or when `dtc`=1 while busy. So a strobe held high never starts a second pass, and a strobe pulsed during a pass is discarded.
- R5: `clock_step_ctrl` is 1 exactly when the block is idle and armed. It therefore rises only after `dtc` has fallen.
- R6: `stop_load`=1 copies `stop_en_in` and `stop_idx_in` into the stop register. When a pass enters the step that equals the stored index while the stored enable is 1, `stopped` goes to 1 and `step_onehot` stays frozen.
- R7: `release_stop`=1 while stopped moves the pass to the next step, or to idle if the frozen step was A7.
- R8: With `free_run`=0 a running pass holds its step and moves by one step for each clock on which `maint_pulse`=1.
- R9: `step_onehot` has at most one bit set, and `busy` is 1 exactly when a bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dtc | input | 1 | Data-transfer-control strobe |
| maint_pulse | input | 1 | Maintenance start or step pulse |
| stop_load | input | 1 | Write strobe for the stop register |
| stop_en_in | input | 1 | Stop enable value to load |
| stop_idx_in | input | 3 | Stop step index value to load |
| release_stop | input | 1 | Lets a halted pass continue |
| free_run | input | 1 | 1: one step per clock; 0: one step per maintenance pulse |
| step_onehot | output | 8 | Active step, bit k = Ak |
| clock_step_ctrl | output | 1 | Idle and armed for a strobe |
| busy | output | 1 | A pass is in progress |
| stopped | output | 1 | Frozen on the stop step |

## Verification
The hardest situations to reach are halts on every possible step, including A0 at the moment of start and A7 just before idle. The bench reaches them by sweeping the stop register over all eight indices, with the stop both enabled and disabled. In each halt it holds the frozen step for several clocks and then releases it. The strobe arming rules are reached in three ways: by holding `dtc` high through reset and past the end of a pass, by pulsing it in the middle of a pass, and by colliding it with a maintenance pulse on the same edge.

// File: rtl/chan_clk_pkg.sv
package chan_clk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } step_state_e;
endpackage

// File: rtl/chan_dtc_arm.sv
module chan_dtc_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic dtc,
    input  logic idle,
    input  logic start_taken,
    output logic armed
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (!dtc) begin
            armed <= 1'b1;
        end else if (!idle || start_taken) begin
            armed <= 1'b0;
        end
    end

    // R4: with the strobe high, arming cannot come back
    a_r4_no_rearm_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && dtc) |=> !armed);
endmodule

// File: rtl/chan_stop_reg.sv
module chan_stop_reg #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en_in,
    input  logic [IDX_W-1:0] idx_in,
    output logic             stop_en,
    output logic [IDX_W-1:0] stop_idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_en  <= 1'b0;
            stop_idx <= '0;
        end else if (load) begin
            stop_en  <= en_in;
            stop_idx <= idx_in;
        end
    end
endmodule

// File: rtl/chan_step_fsm.sv
module chan_step_fsm
    import chan_clk_pkg::*;
#(
    parameter int NUM_STEPS = 8,
    parameter int IDX_W     = $clog2(NUM_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             free_run,
    input  logic             maint_pulse,
    input  logic             release_stop,
    input  logic             stop_en,
    input  logic [IDX_W-1:0] stop_idx,
    output step_state_e      state,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);

    step_state_e      state_n;
    logic [IDX_W-1:0] idx_n;
    logic             advance;
    logic [IDX_W-1:0] idx_inc;

    assign idx_inc = idx + 1'b1;
    assign advance = (state == ST_RUN  && (free_run || maint_pulse)) ||
                     (state == ST_HALT && release_stop);

    always_comb begin
        state_n = state;
        idx_n   = idx;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    idx_n   = '0;
                    state_n = (stop_en && stop_idx == '0) ? ST_HALT : ST_RUN;
                end
            end
            ST_RUN, ST_HALT: begin
                if (advance) begin
                    if (idx == LAST_IDX) begin
                        idx_n   = '0;
                        state_n = ST_IDLE;
                    end else begin
                        idx_n   = idx_inc;
                        state_n = (stop_en && stop_idx == idx_inc) ? ST_HALT : ST_RUN;
                    end
                end
            end
            default: begin
                idx_n   = '0;
                state_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
        end
    end

    // R2: an accepted start leads to step A0
    a_r2_start_a0: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state != ST_IDLE && idx == '0));
    // R6: a halt without release keeps the same step
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !release_stop) |=> (state == ST_HALT && $stable(idx)));
    // R7: releasing the final step ends the pass
    a_r7_last_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && release_stop && idx == LAST_IDX) |=> state == ST_IDLE);
    // R8: in stepped mode, no pulse means no movement
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !free_run && !maint_pulse) |=> (state == ST_RUN && $stable(idx)));
endmodule

// File: rtl/chan_clk_stepper.sv
module chan_clk_stepper
    import chan_clk_pkg::*;
#(
    parameter int NUM_STEPS = 8,
    parameter int IDX_W     = $clog2(NUM_STEPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dtc,
    input  logic                 maint_pulse,
    input  logic                 stop_load,
    input  logic                 stop_en_in,
    input  logic [IDX_W-1:0]     stop_idx_in,
    input  logic                 release_stop,
    input  logic                 free_run,
    output logic [NUM_STEPS-1:0] step_onehot,
    output logic                 clock_step_ctrl,
    output logic                 busy,
    output logic                 stopped
);
    step_state_e      state;
    logic [IDX_W-1:0] idx;
    logic             armed;
    logic             idle;
    logic             start_req;
    logic             stop_en;
    logic [IDX_W-1:0] stop_idx;

    assign idle      = (state == ST_IDLE);
    assign start_req = maint_pulse || (dtc && armed);

    chan_dtc_arm u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dtc         (dtc),
        .idle        (idle),
        .start_taken (idle && start_req),
        .armed       (armed)
    );

    chan_stop_reg #(.IDX_W(IDX_W)) u_stop (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (stop_load),
        .en_in    (stop_en_in),
        .idx_in   (stop_idx_in),
        .stop_en  (stop_en),
        .stop_idx (stop_idx)
    );

    chan_step_fsm #(.NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start_req),
        .free_run     (free_run),
        .maint_pulse  (maint_pulse),
        .release_stop (release_stop),
        .stop_en      (stop_en),
        .stop_idx     (stop_idx),
        .state        (state),
        .idx          (idx)
    );

    always_comb begin
        busy            = (state != ST_IDLE);
        stopped         = (state == ST_HALT);
        clock_step_ctrl = idle && armed;
    end

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
        assign step_onehot[g] = busy && (idx == IDX_W'(g));
    end

    // R9: at most one step, and busy tracks the vector
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_onehot) && (busy == (step_onehot != '0)));
    // R5: ready indication never overlaps a pass
    a_r5_ctrl_idle: assert property (@(posedge clk) disable iff (!rst_n)
        clock_step_ctrl |-> !busy);
endmodule

// File: tb/chan_clk_stepper_test.sv
module chan_clk_stepper_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dtc = 1'b0;
    logic       maint_pulse = 1'b0;
    logic       stop_load = 1'b0;
    logic       stop_en_in = 1'b0;
    logic [2:0] stop_idx_in = 3'd0;
    logic       release_stop = 1'b0;
    logic       free_run = 1'b1;
    logic [7:0] step_onehot;
    logic       clock_step_ctrl;
    logic       busy;
    logic       stopped;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    chan_clk_stepper uut (
        .clk(clk), .rst_n(rst_n), .dtc(dtc), .maint_pulse(maint_pulse),
        .stop_load(stop_load), .stop_en_in(stop_en_in), .stop_idx_in(stop_idx_in),
        .release_stop(release_stop), .free_run(free_run),
        .step_onehot(step_onehot), .clock_step_ctrl(clock_step_ctrl),
        .busy(busy), .stopped(stopped)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_stop(bit en, int s);
        @(negedge clk);
        stop_load = 1'b1; stop_en_in = en; stop_idx_in = 3'(s);
        @(negedge clk);
        stop_load = 1'b0;
    endtask

    // Caller is at a negedge where A0 is shown; walks the pass in free run
    task automatic run_seq(int s, bit en);
        for (int j = 0; j < 8; j++) begin
            bit stp = en && (j == s);
            chk("R3 step", step_onehot, 32'(1) << j);
            chk("R9 busy", busy, 1);
            chk("R5 ctrl low while busy", clock_step_ctrl, 0);
            chk("R6 stopped", stopped, stp);
            if (stp) begin
                for (int h = 0; h < 3; h++) begin
                    @(negedge clk);
                    chk("R6 frozen step", step_onehot, 32'(1) << j);
                    chk("R6 stays stopped", stopped, 1);
                end
                release_stop = 1'b1;
                @(negedge clk);
                release_stop = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk("R7 R3 idle after pass", step_onehot, 0);
        chk("R9 busy low", busy, 0);
    endtask

    task automatic run_cycle(int s, bit en);
        @(negedge clk);
        maint_pulse = 1'b1;
        @(negedge clk);
        maint_pulse = 1'b0;
        run_seq(s, en);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset step", step_onehot, 0);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset stopped", stopped, 0);
        chk("R1 reset ctrl", clock_step_ctrl, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: stop register cleared by reset
        load_stop(1'b1, 2);
        do_reset();
        run_cycle(2, 1'b0);

        // R6 R7 sweep of every stop index, enabled and disabled
        for (int en = 0; en < 2; en++) begin
            for (int s = 0; s < 8; s++) begin
                load_stop(1'(en), s);
                run_cycle(s, 1'(en));
            end
        end
        load_stop(1'b0, 0);

        // R5: idle with dtc low is armed
        @(negedge clk);
        chk("R5 ctrl armed idle", clock_step_ctrl, 1);

        // R2 R4: strobe start, then held high must not restart
        dtc = 1'b1;
        @(negedge clk);
        run_seq(0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R4 held dtc no second pass", busy, 0);
            chk("R5 ctrl low while dtc high", clock_step_ctrl, 0);
        end
        dtc = 1'b0;
        @(negedge clk);
        chk("R5 ctrl rises after dtc falls", clock_step_ctrl, 1);

        // R4: dtc held through reset never starts
        dtc = 1'b1;
        do_reset();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R4 dtc high since reset", busy, 0);
        end
        dtc = 1'b0;
        @(negedge clk);
        chk("R5 ctrl after fall", clock_step_ctrl, 1);

        // R2: simultaneous strobe and pulse give one pass
        dtc = 1'b1; maint_pulse = 1'b1;
        @(negedge clk);
        maint_pulse = 1'b0;
        run_seq(0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R2 only one pass", busy, 0);
        end
        dtc = 1'b0;
        @(negedge clk);

        // R4: strobe pulsed mid-pass is discarded
        maint_pulse = 1'b1;
        @(negedge clk);
        maint_pulse = 1'b0;
        for (int j = 0; j < 8; j++) begin
            chk("R4 pass unaffected by dtc", step_onehot, 32'(1) << j);
            if (j == 3) dtc = 1'b1;
            if (j == 4) dtc = 1'b0;
            @(negedge clk);
        end
        for (int k = 0; k < 4; k++) begin
            chk("R4 mid-pass strobe discarded", busy, 0);
            @(negedge clk);
        end

        // R8: stepped mode
        free_run = 1'b0;
        maint_pulse = 1'b1;
        @(negedge clk);
        maint_pulse = 1'b0;
        chk("R8 first step", step_onehot, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 held without pulse", step_onehot, 1);
        end
        for (int j = 1; j < 8; j++) begin
            maint_pulse = 1'b1;
            @(negedge clk);
            maint_pulse = 1'b0;
            chk("R8 one step per pulse", step_onehot, 32'(1) << j);
            @(negedge clk);
            chk("R8 static level", step_onehot, 32'(1) << j);
        end
        maint_pulse = 1'b1;
        @(negedge clk);
        maint_pulse = 1'b0;
        chk("R8 idle after A7", busy, 0);
        free_run = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule